// File: doc/BRIEF.md
# Dual-Path Fractional/Integer Multiplier

This block is the multiply stage of a DSP datapath. Two 16-bit operands are each widened to 17 bits under their own signedness control, so one signed 17-by-17 core covers signed, unsigned and mixed-sign multiplies. In DSP mode the product goes through a scaler. Integer mode passes it unchanged. Fractional mode treats the operands as Q15 and doubles the product to give a 1.31 value. The scaled value is 33 bits wide and is sign-extended to a 40-bit word, ready for a guard-bit accumulator.

A second, plain integer path serves general-purpose multiply operations. In word form it returns a 32-bit product. In byte form it multiplies only the low eight bits of each operand and returns a 16-bit product.

Both results are registered. In any cycle only one path loads: the path that is not selected keeps its last result.

Top module: `mulDualPath`

## Requirements
- R1: While `rstN` is low, `prod40` and `mcuResult` are both zero.
- R2: Results appear on the outputs at the first rising clock edge after the inputs are presented, so the latency is one cycle.
- R3: Each operand is widened to 17 bits on its own. It is sign-extended when its signed control is 1 and zero-extended when that control is 0, which makes mixed-sign products exact.
- R4: In DSP integer mode (`mcuMode`=0, `fracMode`=0), `prod40` is the exact product of the widened operands, sign-extended from bit 32 to 40 bits.
- R5: In DSP fractional mode (`mcuMode`=0, `fracMode`=1), the product is shifted left by one bit and kept to 33 bits (bits 32:0), then sign-extended to 40 bits. For example, 0x8000 × 0x8000 with both operands signed gives 0x0080000000.
- R6: Every fractional-mode result has bit 0 of `prod40` equal to 0.
- R7: In MCU word mode (`mcuMode`=1, `byteMode`=0), `mcuResult` is bits 31:0 of the product of the widened 16-bit operands.
- R8: In MCU byte mode (`mcuMode`=1, `byteMode`=1), only bits 7:0 of each operand are used, each extended according to its own signed control. The 16-bit product goes to `mcuResult[15:0]` and `mcuResult[31:16]` is 0. Operand bits 15:8 have no effect.
- R9: While `mcuMode` is 1, `prod40` holds its value. While `mcuMode` is 0, `mcuResult` holds its value.
- R10: `fracMode` has no effect on the MCU path, and `byteMode` has no effect on the DSP path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| aSigned | input | 1 | 1 = opA is two's complement |
| bSigned | input | 1 | 1 = opB is two's complement |
| fracMode | input | 1 | DSP path: 1 = Q15 fractional scaling, 0 = integer |
| byteMode | input | 1 | MCU path: 1 = byte operands, 0 = word operands |
| mcuMode | input | 1 | 1 = MCU path loads, 0 = DSP path loads |
| prod40 | output | 40 | Sign-extended DSP product |
| mcuResult | output | 32 | MCU integer product |

## Verification
Each result, on either path, is due at the first rising edge after its inputs are applied, and the unselected output must stay unchanged at that same edge. The bench changes inputs on the falling edge, waits for exactly one rising edge, and samples a quarter period later. Any extra or missing register stage therefore shows up as a stale value. The hold checks compare against the value the bench recorded from the previous operation on that path, so a path that reloads when it should not is caught at the exact cycle.

// File: rtl/mulPkg.sv
package mulPkg;
  localparam int OP_W   = 16;
  localparam int BYTE_W = 8;
  localparam int CORE_W = OP_W + 1;
  localparam int PROD_W = 2 * OP_W + 1;
  localparam int ACC_W  = 40;
  localparam int MCU_W  = 2 * OP_W;
  localparam int HALF_W = 2 * BYTE_W;

  typedef struct packed {
    logic loadDsp;
    logic loadMcu;
    logic byteOps;
    logic fracScale;
  } mulCtrl_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
(
  input  logic     fracMode,
  input  logic     byteMode,
  input  logic     mcuMode,
  output mulCtrl_t ctrl
);
  always_comb begin
    ctrl.loadDsp   = ~mcuMode;
    ctrl.loadMcu   = mcuMode;
    ctrl.byteOps   = mcuMode & byteMode;
    ctrl.fracScale = ~mcuMode & fracMode;
  end
endmodule

// File: rtl/mulOpExtend.sv
module mulOpExtend #(
  parameter int IN_W   = 16,
  parameter int NARROW = 8,
  parameter int OUT_W  = 17
) (
  input  logic [IN_W-1:0]  opIn,
  input  logic             isSigned,
  input  logic             narrow,
  output logic [OUT_W-1:0] opOut
);
  localparam int PAD_WIDE   = OUT_W - IN_W;
  localparam int PAD_NARROW = OUT_W - NARROW;

  logic wideSign;
  logic narrowSign;

  always_comb begin
    wideSign   = isSigned & opIn[IN_W-1];
    narrowSign = isSigned & opIn[NARROW-1];
    if (narrow)
      opOut = {{PAD_NARROW{narrowSign}}, opIn[NARROW-1:0]};
    else
      opOut = {{PAD_WIDE{wideSign}}, opIn};
  end
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mulCtrl_t          ctrl,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              aSigned,
  input  logic              bSigned,
  output logic [ACC_W-1:0]  prod40,
  output logic [MCU_W-1:0]  mcuResult
);
  localparam int GUARD_W = ACC_W - PROD_W;

  logic [OP_W-1:0]   opsIn  [2];
  logic              sgnIn  [2];
  logic [CORE_W-1:0] opsExt [2];

  assign opsIn[0] = opA;
  assign opsIn[1] = opB;
  assign sgnIn[0] = aSigned;
  assign sgnIn[1] = bSigned;

  for (genvar i = 0; i < 2; i++) begin : g_ext
    mulOpExtend #(.IN_W(OP_W), .NARROW(BYTE_W), .OUT_W(CORE_W)) uExt (
      .opIn    (opsIn[i]),
      .isSigned(sgnIn[i]),
      .narrow  (ctrl.byteOps),
      .opOut   (opsExt[i])
    );
  end

  logic signed [PROD_W-1:0] rawProd;
  logic        [PROD_W-1:0] scaled;
  logic        [ACC_W-1:0]  dspNext;
  logic        [MCU_W-1:0]  mcuNext;

  always_comb begin
    rawProd = $signed(opsExt[0]) * $signed(opsExt[1]);
    scaled  = ctrl.fracScale ? {rawProd[PROD_W-2:0], 1'b0} : rawProd;
    dspNext = {{GUARD_W{scaled[PROD_W-1]}}, scaled};
    if (ctrl.byteOps)
      mcuNext = {{(MCU_W-HALF_W){1'b0}}, rawProd[HALF_W-1:0]};
    else
      mcuNext = rawProd[MCU_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prod40    <= '0;
      mcuResult <= '0;
    end else begin
      if (ctrl.loadDsp) prod40    <= dspNext;
      if (ctrl.loadMcu) mcuResult <= mcuNext;
    end
  end

  p_dsp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadMcu |=> $stable(prod40));
  p_mcu_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadDsp |=> $stable(mcuResult));
  p_frac_lsb_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fracScale |=> (prod40[0] == 1'b0));
  p_byte_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.byteOps |=> (mcuResult[MCU_W-1:HALF_W] == '0));
  p_unsigned_pos_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadDsp && !ctrl.fracScale && !aSigned && !bSigned) |=> !prod40[ACC_W-1]);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |-> (prod40 == '0 && mcuResult == '0));
endmodule

// File: rtl/mulDualPath.sv
module mulDualPath
  import mulPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        aSigned,
  input  logic        bSigned,
  input  logic        fracMode,
  input  logic        byteMode,
  input  logic        mcuMode,
  output logic [39:0] prod40,
  output logic [31:0] mcuResult
);
  mulCtrl_t ctrl;

  mulCtrl uCtrl (
    .fracMode(fracMode),
    .byteMode(byteMode),
    .mcuMode (mcuMode),
    .ctrl    (ctrl)
  );

  mulDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .aSigned  (aSigned),
    .bSigned  (bSigned),
    .prod40   (prod40),
    .mcuResult(mcuResult)
  );
endmodule

// File: tb/mulDualPath_test.sv
`timescale 1ns/1ps
module mulDualPath_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        aSigned = 1'b0, bSigned = 1'b0;
  logic        fracMode = 1'b0, byteMode = 1'b0, mcuMode = 1'b0;
  logic [39:0] prod40;
  logic [31:0] mcuResult;

  int checks = 0;
  int fails = 0;
  logic [39:0] lastDsp = '0;
  logic [31:0] lastMcu = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mulDualPath uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .fracMode(fracMode),
    .byteMode(byteMode), .mcuMode(mcuMode),
    .prod40(prod40), .mcuResult(mcuResult)
  );

  function automatic longint extendOp(logic [15:0] v, bit s, bit nar);
    if (nar) return s ? longint'($signed(v[7:0])) : longint'(v[7:0]);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [39:0] expDsp(logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr);
    longint p;
    logic [63:0] pv;
    p = extendOp(a, as, 1'b0) * extendOp(b, bs, 1'b0);
    if (fr) p = p * 2;
    pv = p;
    return {{7{pv[32]}}, pv[32:0]};
  endfunction

  function automatic logic [31:0] expMcu(logic [15:0] a, logic [15:0] b, bit as, bit bs, bit by);
    longint p;
    logic [63:0] pv;
    p = extendOp(a, as, by) * extendOp(b, bs, by);
    pv = p;
    return by ? {16'h0, pv[15:0]} : pv[31:0];
  endfunction

  task automatic check40(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s prod40 actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mcuResult actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply on falling edge, wait one rising edge, sample 1.25 ns later.
  task automatic applyOp(logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr, bit by, bit mcu);
    @(negedge clk);
    opA = a; opB = b; aSigned = as; bSigned = bs;
    fracMode = fr; byteMode = by; mcuMode = mcu;
    @(posedge clk);
    #1.25;
  endtask

  task automatic dspOp(string req, logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr, bit by);
    logic [39:0] e;
    e = expDsp(a, b, as, bs, fr);
    applyOp(a, b, as, bs, fr, by, 1'b0);
    check40(req, prod40, e);
    check32({req, " R9 hold"}, mcuResult, lastMcu);
    lastDsp = e;
  endtask

  task automatic mcuOp(string req, logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr, bit by);
    logic [31:0] e;
    e = expMcu(a, b, as, bs, by);
    applyOp(a, b, as, bs, fr, by, 1'b1);
    check32(req, mcuResult, e);
    check40({req, " R9 hold"}, prod40, lastDsp);
    lastMcu = e;
  endtask

  task automatic tReset();
    opA = 16'hFFFF; opB = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1.25;
    check40("R1", prod40, 40'h0);
    check32("R1", mcuResult, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tLatency();
    // R2: value present exactly one edge after the inputs.
    dspOp("R2", 16'd300, 16'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    check40("R2 value", prod40, 40'd2100);
  endtask

  task automatic tInteger();
    dspOp("R4 pos", 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0);
    dspOp("R4 neg", 16'hFFFF, 16'h0003, 1'b1, 1'b1, 1'b0, 1'b0);
    check40("R4 neg value", prod40, 40'hFFFFFFFFFD);
    dspOp("R3 unsigned", 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    check40("R3 unsigned value", prod40, 40'h00FFFE0001);
    dspOp("R3 mixed", 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    check40("R3 mixed value", prod40, 40'hFFFFFF0001);
    dspOp("R3 mixed b", 16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tFrac();
    dspOp("R5 minus one squared", 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0);
    check40("R5 plus one", prod40, 40'h0080000000);
    dspOp("R5 half", 16'h4000, 16'hC000, 1'b1, 1'b1, 1'b1, 1'b0);
    check40("R5 minus quarter", prod40, 40'hFFE0000000);
    dspOp("R6 odd", 16'h7FFF, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
    checks++;
    if (prod40[0] !== 1'b0) begin
      fails++;
      $display("FAIL R6 lsb actual=%b expected=0", prod40[0]);
    end
  endtask

  task automatic tMcuWord();
    mcuOp("R7 signed", 16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0);
    mcuOp("R7 unsigned", 16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0);
    check32("R7 value", mcuResult, 32'h0001FFFE);
    mcuOp("R7 mixed", 16'hFFFE, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tMcuByte();
    mcuOp("R8 unsigned", 16'hA5FF, 16'h3CFF, 1'b0, 1'b0, 1'b0, 1'b1);
    check32("R8 value", mcuResult, 32'h0000FE01);
    mcuOp("R8 signed", 16'h0080, 16'hFF80, 1'b1, 1'b1, 1'b0, 1'b1);
    check32("R8 signed value", mcuResult, 32'h00004000);
    mcuOp("R8 mixed", 16'h12FF, 16'h34FF, 1'b1, 1'b0, 1'b0, 1'b1);
    check32("R8 mixed value", mcuResult, 32'h0000FF01);
  endtask

  task automatic tIgnore();
    // R10: fracMode set on MCU path, byteMode set on DSP path.
    mcuOp("R10 frac ignored", 16'h0003, 16'h0005, 1'b1, 1'b1, 1'b1, 1'b0);
    check32("R10 frac value", mcuResult, 32'd15);
    dspOp("R10 byte ignored", 16'h0102, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b1);
    check40("R10 byte value", prod40, 40'h0000010200);
    mcuOp("R9 alternating", 16'h0010, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    tReset();
    tLatency();
    tInteger();
    tFrac();
    tMcuWord();
    tMcuByte();
    tIgnore();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule